// File: doc/BRIEF.md
# Indirect Interrupt Redirection Window

This block is an interrupt router whose configuration is reached through only two 32-bit locations. Software writes an internal register number into the select location and then reads or writes the data window. The window then reaches the register with that number. The internal space holds a unit identification register and one redirection entry for each input pin. Each entry is two words: the low word holds the vector, delivery mode, destination mode, polarity, trigger mode and mask. The high word holds the destination.

Each input pin is first corrected for its programmed polarity. It is then qualified as an edge or a level source. An unmasked pin that qualifies leaves a request pending. A fixed-priority picker presents one pending request at a time as a message that carries the entry's fields. Downstream transport consumes the message with an acknowledge pulse. For level sources, a remote-acknowledge flag then blocks new requests until an end-of-interrupt arrives with the entry's vector. The number of pins, the table base index, the destination width and the picking order are parameters.

Top module: `irq_route_window`

## Requirements
- R1: A bus write with `bus_addr`=0 loads the select register. With `bus_addr`=0 the read data returns the select value. With `bus_addr`=1, reads and writes reach the internal register that the select value numbers.
- R2: The entry of pin p is at index TBL_BASE+2p (low word) and TBL_BASE+2p+1 (high word); default TBL_BASE is 16. Low word: vector [7:0], delivery mode [10:8], destination mode [11] (1 = logical), delivery status [12], polarity [13] (1 = active low), remote-acknowledge [14], trigger [15] (1 = level), mask [16] (1 = masked). High word: destination [31:24]. All other bits read 0.
- R3: Index ID_INDEX (default 0) is the identification register. Bits [27:24] keep the last value written there, and all other bits read 0.
- R4: After reset every low word reads 0x0001_0000 (masked, all else zero). Every high word, the identification register and the select register read 0, and no message is presented.
- R5: An index that is neither the identification register nor a table entry reads 0, and writing it changes no register.
- R6: A masked pin never produces a message. Writing the mask bit to 1 withdraws a pending request at the same clock edge.
- R7: An edge pin (trigger 0) leaves one request per inactive-to-active transition of its polarity-corrected input. Holding the input active after the acknowledge raises no further request.
- R8: A level pin (trigger 1) requests while its corrected input is active and its remote-acknowledge bit is 0, and it withdraws the request when the input goes inactive. Acknowledging the request sets the remote-acknowledge bit. Only an `eoi_valid` pulse whose `eoi_vector` equals the entry's vector clears the bit.
- R9: The message carries the presented pin's number, vector, 3-bit delivery code (0 fixed, 1 lowest priority, 2 system management, 3 reserved, 4 non-maskable, 5 init, 6 startup, 7 external), destination mode, trigger mode and destination. With the default order, the lowest-numbered pending pin is presented first.
- R10: The delivery status bit reads 1 exactly while the entry has a request pending. Writes to the status and remote-acknowledge bits are ignored.
- R11: `msg_ack` high while a message is presented clears that pin's pending request at the same edge, and the next pending pin is presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 = select register, 1 = data window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed location |
| pin_in | input | NPINS | Interrupt input pins |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_vector | input | 8 | Vector being retired |
| msg_valid | output | 1 | A request message is presented |
| msg_pin | output | $clog2(NPINS) | Pin number of the message |
| msg_vector | output | 8 | Vector of the message |
| msg_delivery | output | 3 | Delivery mode code |
| msg_dest_logical | output | 1 | Destination mode (1 = logical) |
| msg_level | output | 1 | Trigger mode (1 = level) |
| msg_dest | output | DEST_W | Destination field |
| msg_ack | input | 1 | Message consumed |

## Verification
The hardest state to reach from the ports is a level pin that has been acknowledged while its input stays active. The only exits from that state are an end-of-interrupt with the right vector or the input going inactive. The stimulus programs an active-low level entry with the pin held low, and it acknowledges the first message. It then sends an end-of-interrupt with a neighbouring vector, which must leave the pin silent, and then one with the exact vector, which must bring the request back. Two edge pins raised in the same cycle check the presentation order and the ack handover. A sweep of all entries with distinct patterns checks the index mapping for aliasing.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

   typedef enum logic [2:0] {
      DLV_FIXED  = 3'd0,
      DLV_LOWEST = 3'd1,
      DLV_SMGMT  = 3'd2,
      DLV_RSVD   = 3'd3,
      DLV_NMASK  = 3'd4,
      DLV_INIT   = 3'd5,
      DLV_START  = 3'd6,
      DLV_EXTERN = 3'd7
   } dlv_mode_e;

   // configuration fields of one entry (low word, software writable part)
   typedef struct packed {
      logic      mask;
      logic      level;
      logic      act_low;
      logic      logical;
      dlv_mode_e dlv;
      logic [7:0] vec;
   } rte_cfg_t;

   localparam int LO_VEC_LSB  = 0;
   localparam int LO_DLV_LSB  = 8;
   localparam int LO_LOGICAL  = 11;
   localparam int LO_STATUS   = 12;
   localparam int LO_ACTLOW   = 13;
   localparam int LO_RIRR     = 14;
   localparam int LO_LEVEL    = 15;
   localparam int LO_MASK     = 16;
   localparam int HI_DEST_LSB = 24;
   localparam int ID_LSB      = 24;
   localparam int ID_W        = 4;

endpackage

// File: rtl/irqw_entry.sv
module irqw_entry
   import irqw_pkg::*;
#(
   parameter int DEST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [31:0]       wdata,
   input  logic              pin_i,
   input  logic              ack_i,
   input  logic              eoi_i,
   input  logic [7:0]        eoi_vec_i,
   output logic [31:0]       lo_o,
   output logic [31:0]       hi_o,
   output logic              req_o,
   output rte_cfg_t          cfg_o,
   output logic [DEST_W-1:0] dest_o
);

   if (DEST_W < 1 || DEST_W > 32 - HI_DEST_LSB) begin : g_bad_dest
      $error("irqw_entry: DEST_W out of range");
   end

   rte_cfg_t          cfg_q;
   logic [DEST_W-1:0] dest_q;
   logic              prev_q;
   logic              pend_q;
   logic              irr_q;
   logic              act;
   logic              rise;
   logic              wdata_unused;

   assign wdata_unused = ^wdata;
   assign act  = pin_i ^ cfg_q.act_low;
   assign rise = act & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         cfg_q.mask <= 1'b1;
         dest_q     <= '0;
         prev_q     <= 1'b0;
         pend_q     <= 1'b0;
         irr_q      <= 1'b0;
      end else begin
         prev_q <= act;

         if (eoi_i && cfg_q.level && eoi_vec_i == cfg_q.vec)
            irr_q <= 1'b0;

         if (cfg_q.mask) begin
            pend_q <= 1'b0;
         end else if (cfg_q.level) begin
            if (!act) begin
               pend_q <= 1'b0;
            end else if (ack_i && pend_q) begin
               pend_q <= 1'b0;
               irr_q  <= 1'b1;
            end else if (!irr_q) begin
               pend_q <= 1'b1;
            end
         end else begin
            if (rise)
               pend_q <= 1'b1;
            else if (ack_i)
               pend_q <= 1'b0;
         end

         if (wr_lo) begin
            cfg_q.vec     <= wdata[LO_VEC_LSB +: 8];
            cfg_q.dlv     <= dlv_mode_e'(wdata[LO_DLV_LSB +: 3]);
            cfg_q.logical <= wdata[LO_LOGICAL];
            cfg_q.act_low <= wdata[LO_ACTLOW];
            cfg_q.level   <= wdata[LO_LEVEL];
            cfg_q.mask    <= wdata[LO_MASK];
            if (!wdata[LO_LEVEL]) irr_q  <= 1'b0;
            if (wdata[LO_MASK])   pend_q <= 1'b0;
         end
         if (wr_hi)
            dest_q <= wdata[HI_DEST_LSB +: DEST_W];
      end
   end

   always_comb begin
      lo_o                       = '0;
      lo_o[LO_VEC_LSB +: 8]      = cfg_q.vec;
      lo_o[LO_DLV_LSB +: 3]      = cfg_q.dlv;
      lo_o[LO_LOGICAL]           = cfg_q.logical;
      lo_o[LO_STATUS]            = pend_q;
      lo_o[LO_ACTLOW]            = cfg_q.act_low;
      lo_o[LO_RIRR]              = irr_q;
      lo_o[LO_LEVEL]             = cfg_q.level;
      lo_o[LO_MASK]              = cfg_q.mask;
      hi_o                       = '0;
      hi_o[HI_DEST_LSB +: DEST_W] = dest_q;
   end

   assign req_o  = pend_q;
   assign cfg_o  = cfg_q;
   assign dest_o = dest_q;

   AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.mask |-> !pend_q);                                          // R6
   AST_IRR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.level && irr_q) |-> !pend_q);                              // R8
   AST_IRR_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      irr_q |-> cfg_q.level);                                           // R8
   AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q.level && !$past(cfg_q.level) && $rose(pend_q))
         |-> ($past(act) && !$past(prev_q)));                           // R7
   AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && pend_q && cfg_q.level) |=> (!pend_q && irr_q));         // R11

endmodule

// File: rtl/irqw_pick.sv
module irqw_pick #(
   parameter int NPINS     = 16,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] req_i,
   output logic [NPINS-1:0] grant_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   if (LOW_FIRST) begin : g_low
      always_comb begin
         grant_o = '0;
         idx_o   = '0;
         for (int i = NPINS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
               grant_o    = '0;
               grant_o[i] = 1'b1;
               idx_o      = IDX_W'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         grant_o = '0;
         idx_o   = '0;
         for (int i = 0; i < NPINS; i++) begin
            if (req_i[i]) begin
               grant_o    = '0;
               grant_o[i] = 1'b1;
               idx_o      = IDX_W'(i);
            end
         end
      end
   end

   assign any_o = |req_i;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));                                               // R9
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ((grant_o & req_i) != '0));                             // R9

endmodule

// File: rtl/irq_route_window.sv
module irq_route_window
   import irqw_pkg::*;
#(
   parameter int NPINS     = 16,
   parameter int DEST_W    = 8,
   parameter int SEL_W     = 8,
   parameter int TBL_BASE  = 16,
   parameter int ID_INDEX  = 0,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = (NPINS > 1) ? $clog2(NPINS) : 1,
   localparam int TBL_END  = TBL_BASE + 2 * NPINS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              eoi_valid,
   input  logic [7:0]        eoi_vector,
   output logic              msg_valid,
   output logic [IDX_W-1:0]  msg_pin,
   output logic [7:0]        msg_vector,
   output logic [2:0]        msg_delivery,
   output logic              msg_dest_logical,
   output logic              msg_level,
   output logic [DEST_W-1:0] msg_dest,
   input  logic              msg_ack
);

   if (NPINS < 1) begin : g_bad_pins
      $error("irq_route_window: NPINS must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 32 || TBL_END > (1 << SEL_W)) begin : g_bad_sel
      $error("irq_route_window: table does not fit the select register");
   end
   if (ID_INDEX >= TBL_BASE && ID_INDEX < TBL_END) begin : g_bad_id
      $error("irq_route_window: identification index overlaps the table");
   end

   logic [SEL_W-1:0]  sel_q;
   logic [ID_W-1:0]   id_q;
   logic              win_wr;
   logic              hit_id;
   logic [NPINS-1:0]  hit_lo;
   logic [NPINS-1:0]  hit_hi;
   logic [NPINS-1:0]  req;
   logic [NPINS-1:0]  grant;
   logic [IDX_W-1:0]  pick;
   logic              pick_any;
   logic [31:0]       lo_w   [NPINS];
   logic [31:0]       hi_w   [NPINS];
   rte_cfg_t          cfg_w  [NPINS];
   logic [DEST_W-1:0] dest_w [NPINS];

   assign win_wr = bus_wr & bus_addr;
   assign hit_id = (sel_q == SEL_W'(ID_INDEX));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (bus_wr && !bus_addr)
            sel_q <= bus_wdata[SEL_W-1:0];
         if (win_wr && hit_id)
            id_q <= bus_wdata[ID_LSB +: ID_W];
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign hit_lo[i] = (sel_q == SEL_W'(TBL_BASE + 2 * i));
      assign hit_hi[i] = (sel_q == SEL_W'(TBL_BASE + 2 * i + 1));

      irqw_entry #(.DEST_W(DEST_W)) u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_lo     (win_wr & hit_lo[i]),
         .wr_hi     (win_wr & hit_hi[i]),
         .wdata     (bus_wdata),
         .pin_i     (pin_in[i]),
         .ack_i     (msg_ack & grant[i]),
         .eoi_i     (eoi_valid),
         .eoi_vec_i (eoi_vector),
         .lo_o      (lo_w[i]),
         .hi_o      (hi_w[i]),
         .req_o     (req[i]),
         .cfg_o     (cfg_w[i]),
         .dest_o    (dest_w[i])
      );
   end

   irqw_pick #(.NPINS(NPINS), .LOW_FIRST(LOW_FIRST)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .grant_o (grant),
      .idx_o   (pick),
      .any_o   (pick_any)
   );

   always_comb begin
      bus_rdata = '0;
      if (!bus_addr) begin
         bus_rdata[SEL_W-1:0] = sel_q;
      end else begin
         if (hit_id)
            bus_rdata[ID_LSB +: ID_W] = id_q;
         for (int i = 0; i < NPINS; i++) begin
            if (hit_lo[i]) bus_rdata = bus_rdata | lo_w[i];
            if (hit_hi[i]) bus_rdata = bus_rdata | hi_w[i];
         end
      end
   end

   assign msg_valid        = pick_any;
   assign msg_pin          = pick;
   assign msg_vector       = cfg_w[pick].vec;
   assign msg_delivery     = cfg_w[pick].dlv;
   assign msg_dest_logical = cfg_w[pick].logical;
   assign msg_level        = cfg_w[pick].level;
   assign msg_dest         = dest_w[pick];

   AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_wr && hit_id) |=> $stable(id_q));                           // R3
   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && !bus_addr) |=> $stable(sel_q));                       // R1
   AST_MSG_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !cfg_w[pick].mask);                                 // R6

endmodule

// File: tb/tb_irq_route_window.sv
module tb_irq_route_window;

   localparam int CLK_PERIOD = 10;
   localparam int NP   = 16;
   localparam int BASE = 16;
   localparam logic [31:0] LO_RW_MASK = 32'h0001_AFFF;
   localparam logic [31:0] LO_RESET   = 32'h0001_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pins = '0;
   logic        eoi_valid = 1'b0;
   logic [7:0]  eoi_vector = '0;
   logic        msg_valid;
   logic [3:0]  msg_pin;
   logic [7:0]  msg_vector;
   logic [2:0]  msg_delivery;
   logic        msg_dest_logical;
   logic        msg_level;
   logic [7:0]  msg_dest;
   logic        msg_ack = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_route_window dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .msg_valid(msg_valid), .msg_pin(msg_pin), .msg_vector(msg_vector),
      .msg_delivery(msg_delivery), .msg_dest_logical(msg_dest_logical),
      .msg_level(msg_level), .msg_dest(msg_dest), .msg_ack(msg_ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_write(input int idx, input logic [31:0] d);
      bus_write(1'b0, 32'(idx));
      bus_write(1'b1, d);
   endtask

   task automatic reg_read(input int idx, output logic [31:0] d);
      bus_write(1'b0, 32'(idx));
      bus_addr = 1'b1;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_ack();
      @(negedge clk); msg_ack = 1'b1;
      @(negedge clk); msg_ack = 1'b0;
   endtask

   task automatic pulse_eoi(input logic [7:0] v);
      @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk); eoi_valid = 1'b0;
   endtask

   function automatic logic [31:0] mk_lo(input logic [7:0] v, input logic [2:0] d,
                                         input logic lg, input logic pol,
                                         input logic lvl, input logic msk);
      return {15'd0, msk, lvl, 1'b0, pol, 1'b0, lg, d, v};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] lw, hw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: reset state
      chk("R4 msg_valid", 32'(msg_valid), 0);
      bus_addr = 1'b0; #1;
      chk("R4 select", bus_rdata, 0);
      reg_read(0, rd); chk("R4 id", rd, 0);
      for (int p = 0; p < NP; p++) begin
         reg_read(BASE + 2 * p, rd);     chk("R4 low word", rd, LO_RESET);
         reg_read(BASE + 2 * p + 1, rd); chk("R4 high word", rd, 0);
      end

      // R1: select readback
      bus_write(1'b0, 32'h0000_00A5);
      bus_addr = 1'b0; #1;
      chk("R1 select readback", bus_rdata, 32'h0000_00A5);

      // R3: identification field retention
      reg_write(0, 32'hFFFF_FFFF); reg_read(0, rd); chk("R3 id all ones", rd, 32'h0F00_0000);
      reg_write(0, 32'h05AB_CDEF); reg_read(0, rd); chk("R3 id pattern", rd, 32'h0500_0000);

      // R2 / R10: distinct pattern per entry, then read back all
      for (int p = 0; p < NP; p++) begin
         reg_write(BASE + 2 * p, 32'hFFFF_F000 | 32'(p * 9));
         reg_write(BASE + 2 * p + 1, {8'(p * 13), 24'hFF_FFFF});
      end
      for (int p = 0; p < NP; p++) begin
         lw = 32'hFFFF_F000 | 32'(p * 9);
         hw = {8'(p * 13), 24'hFF_FFFF};
         reg_read(BASE + 2 * p, rd);     chk("R2 R10 low word map", rd, lw & LO_RW_MASK);
         reg_read(BASE + 2 * p + 1, rd); chk("R2 high word map", rd, hw & 32'hFF00_0000);
      end
      chk("R6 masked entries silent", 32'(msg_valid), 0);
      for (int p = 0; p < NP; p++) begin
         reg_write(BASE + 2 * p, LO_RESET);
         reg_write(BASE + 2 * p + 1, 0);
      end

      // R5: unimplemented indices
      for (int i = 1; i < 256; i++) begin
         if (i < BASE || i >= BASE + 2 * NP) begin
            reg_write(i, 32'hFFFF_FFFF);
            reg_read(i, rd);
            if (rd !== 0) chk("R5 unimplemented reads zero", rd, 0);
         end
      end
      chk("R5 sweep done", 0, 0);
      reg_read(0, rd);        chk("R5 id untouched", rd, 32'h0500_0000);
      reg_read(BASE, rd);     chk("R5 entry untouched", rd, LO_RESET);
      reg_read(BASE + 1, rd); chk("R5 entry hi untouched", rd, 0);

      // R7 / R9 / R10 / R11 / R6: edge pins one by one
      for (int p = 0; p < NP; p++) begin
         logic [7:0] v;
         logic [2:0] d;
         logic [7:0] ds;
         v = 8'h40 + 8'(p); d = 3'(p % 8); ds = 8'(p * 17);
         reg_write(BASE + 2 * p + 1, {ds, 24'h0});
         reg_write(BASE + 2 * p, mk_lo(v, d, p[0], 1'b0, 1'b0, 1'b0));
         @(negedge clk); pins[p] = 1'b1;
         @(negedge clk);
         chk("R9 valid", 32'(msg_valid), 1);
         chk("R9 pin", 32'(msg_pin), 32'(p));
         chk("R9 vector", 32'(msg_vector), 32'(v));
         chk("R9 delivery", 32'(msg_delivery), 32'(d));
         chk("R9 dest mode", 32'(msg_dest_logical), 32'(p[0]));
         chk("R9 trigger", 32'(msg_level), 0);
         chk("R9 dest", 32'(msg_dest), 32'(ds));
         reg_read(BASE + 2 * p, rd);
         chk("R10 status pending", rd, mk_lo(v, d, p[0], 1'b0, 1'b0, 1'b0) | 32'h0000_1000);
         pulse_ack();
         chk("R11 ack clears", 32'(msg_valid), 0);
         repeat (3) @(negedge clk);
         chk("R7 held input no repeat", 32'(msg_valid), 0);
         reg_read(BASE + 2 * p, rd);
         chk("R10 status idle", rd, mk_lo(v, d, p[0], 1'b0, 1'b0, 1'b0));
         pins[p] = 1'b0;
         reg_write(BASE + 2 * p, LO_RESET);
         @(negedge clk); pins[p] = 1'b1;
         repeat (2) @(negedge clk);
         chk("R6 masked edge ignored", 32'(msg_valid), 0);
         pins[p] = 1'b0;
         @(negedge clk);
      end

      // R7: second edge gives second request
      reg_write(BASE + 2 * 4, mk_lo(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk); pins[4] = 1'b1;
      @(negedge clk); pulse_ack();
      pins[4] = 1'b0;
      @(negedge clk); pins[4] = 1'b1;
      @(negedge clk);
      chk("R7 new edge new request", 32'(msg_valid), 1);
      pulse_ack();
      pins[4] = 1'b0;
      reg_write(BASE + 2 * 4, LO_RESET);

      // R8: level, active-low pin 3 held low (active)
      pins[3] = 1'b0;
      reg_write(BASE + 2 * 3 + 1, 32'hAA00_0000);
      reg_write(BASE + 2 * 3, mk_lo(8'h77, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0));
      repeat (2) @(negedge clk);
      chk("R8 level request", 32'(msg_valid), 1);
      chk("R8 level pin", 32'(msg_pin), 3);
      chk("R8 level flag", 32'(msg_level), 1);
      chk("R9 level dest", 32'(msg_dest), 32'hAA);
      pulse_ack();
      chk("R8 ack drops request", 32'(msg_valid), 0);
      reg_read(BASE + 2 * 3, rd);
      chk("R8 remote ack bit", rd, mk_lo(8'h77, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0) | 32'h0000_4000);
      pulse_eoi(8'h76);
      repeat (2) @(negedge clk);
      chk("R8 wrong eoi vector ignored", 32'(msg_valid), 0);
      pulse_eoi(8'h77);
      repeat (2) @(negedge clk);
      chk("R8 matching eoi rearms", 32'(msg_valid), 1);
      pins[3] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 inactive input withdraws", 32'(msg_valid), 0);
      reg_write(BASE + 2 * 3, LO_RESET);
      pins[3] = 1'b0;

      // R6: masking a pending request withdraws it
      reg_write(BASE + 2 * 5, mk_lo(8'h55, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk); pins[5] = 1'b1;
      @(negedge clk);
      chk("R6 pending before mask", 32'(msg_valid), 1);
      reg_write(BASE + 2 * 5, mk_lo(8'h55, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1));
      chk("R6 mask withdraws", 32'(msg_valid), 0);
      reg_read(BASE + 2 * 5, rd);
      chk("R6 R10 status after mask", rd, mk_lo(8'h55, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1));
      pins[5] = 1'b0;

      // R9 / R11: two pins at once, lowest first
      reg_write(BASE + 2 * 2, mk_lo(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      reg_write(BASE + 2 * 9, mk_lo(8'h99, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk); pins[2] = 1'b1; pins[9] = 1'b1;
      @(negedge clk);
      chk("R9 priority first pin", 32'(msg_pin), 2);
      chk("R9 priority first vector", 32'(msg_vector), 32'h22);
      pulse_ack();
      chk("R11 handover valid", 32'(msg_valid), 1);
      chk("R11 handover pin", 32'(msg_pin), 9);
      chk("R9 extern delivery", 32'(msg_delivery), 7);
      pulse_ack();
      chk("R11 all drained", 32'(msg_valid), 0);

      finish_run();
   end

endmodule